// File: doc/BRIEF.md
# Five-Level Multi-Carrier Sine PWM Gate Generator

This block drives one phase leg built from two series H-bridge cells, each with its own DC source, so the leg can put five voltage steps on its terminal. Each clock it takes a signed digital reference sample. It compares that sample against a stack of four triangular carriers and turns the result into a target level from -2 to +2. The level is then split across the two cells. Each cell is driven by a small state machine that picks a positive, negative or zero bridge state, and the four switch commands that result pass through a dead-time stage before they reach the gate outputs.

All carriers come from one shared up/down ramp. The software-chosen limit `ramp_lim` sets both the carrier period and the height of each carrier band, and band k is shifted by k band heights. The `arr_mode` input picks which carriers run inverted. When a cell drops back to zero output, it alternates between its two redundant zero switch pairs. This spreads conduction over all four switches.

The ramp register has two states, RAMP_UP and RAMP_DN. Each cell machine has four states: CS_POS (S1+S4 on), CS_NEG (S2+S3 on), CS_ZHI (S1+S2 on) and CS_ZLO (S3+S4 on). Its transitions are:

- "drive-up": any state to CS_POS.
- "drive-down": any state to CS_NEG.
- "settle": CS_POS or CS_NEG to the zero pair not used last.
- "hold-zero": a zero state stays where it is.

Top module: `ml_spwm_gen`

## Requirements
- R1: While `rst_n` is low, every gate output is 0 and `lvl_o` is 0. Both cells leave reset in CS_ZLO, so after release S3 and S4 of each cell (gate_o = 8'hCC) turn on once the dead time has run out.
- R2: One ramp runs 0,1,…,L,L-1,…,0,1,… with L = `ramp_lim`, giving a period of 2L clocks. Carrier k (k = 0..3) is (k-2)·L plus either the ramp (normal) or L minus the ramp (inverted). With L = 0 the ramp stays at 0.
- R3: `lvl_o` is registered one clock after the ramp and reference it was computed from. Its value is the number of carriers strictly below `ref_in`, minus 2, so it always lies in -2..+2.
- R4: `arr_mode` = 0 (in-phase stacking) runs no carrier inverted.
- R5: `arr_mode` = 1 (opposed halves) inverts carriers 2 and 3, which lie above zero, and leaves carriers 0 and 1 normal.
- R6: `arr_mode` = 2 (alternating) inverts carriers 1 and 3. `arr_mode` = 3 behaves exactly like mode 0.
- R7: Cell 0 goes to CS_POS when the registered level is ≥ +1 and to CS_NEG when it is ≤ -1. Cell 1 does the same for ≥ +2 and ≤ -2. Switch bit order in `gate_o` is bit 4c+s-1 = switch Ss of cell c.
- R8: Each time a cell settles from CS_POS or CS_NEG to zero, it uses the opposite zero pair (CS_ZHI or CS_ZLO) from the one it used last. The first zero after reset counts as CS_ZLO.
- R9: A gate output rises `dead_cyc`+1 clocks after its switch command rises and falls one clock after the command falls. When `dead_cyc` > 0, both switches of a half-bridge are therefore off for at least `dead_cyc` clocks around every hand-over.
- R10: S1 and S3 of a cell are never on together, and neither are S2 and S4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_in | input | DATA_W | Signed reference sample, same scale as the carriers (±2·ramp_lim) |
| arr_mode | input | 2 | Carrier arrangement: 0 in-phase, 1 opposed halves, 2 alternating, 3 as 0 |
| ramp_lim | input | CNT_W | Ramp peak value L (carrier band height and half period) |
| dead_cyc | input | DEAD_W | Dead time in clocks added to every switch turn-on |
| lvl_o | output | LVL_W | Signed target level, -2..+2 |
| gate_o | output | 4·NCELL | Switch gate commands, bit 4c+s-1 is switch Ss of cell c |

## Verification
The critical overlap is a level change that lands while a dead-time window is still counting on the same half-bridge. The zero-pair alternation then picks a new pair at the very clock the delayed turn-on of the previous command would have completed. The bench provokes this by running a carrier limit of 1 with a non-zero dead time, so the level moves nearly every clock, faster than the dead band. A behavioural model with integer state predicts the level and all eight gates on every clock, and the design is judged against it. Any mismatch is attributed to the dead-time, zero-alternation or level-mapping requirement, according to which of these is active in the model at that moment.

// File: rtl/ml_spwm_pkg.sv
package ml_spwm_pkg;

    typedef enum logic [1:0] {
        ARR_PD    = 2'd0,
        ARR_POD   = 2'd1,
        ARR_APOD  = 2'd2,
        ARR_SPARE = 2'd3
    } arr_mode_e;

    typedef enum logic [1:0] {
        CS_POS = 2'd0,
        CS_NEG = 2'd1,
        CS_ZHI = 2'd2,
        CS_ZLO = 2'd3
    } cell_st_e;

    typedef enum logic {
        RAMP_UP = 1'b0,
        RAMP_DN = 1'b1
    } ramp_dir_e;

    // Whether carrier idx of ncar runs inverted under arrangement m
    function automatic logic carrier_flipped(arr_mode_e m, int unsigned idx, int unsigned ncar);
        logic f;
        unique case (m)
            ARR_PD:    f = 1'b0;
            ARR_POD:   f = (idx >= ncar / 2);
            ARR_APOD:  f = ((idx % 2) == 1);
            ARR_SPARE: f = 1'b0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/ml_spwm_ramp.sv
module ml_spwm_ramp
    import ml_spwm_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] lim_i,
    output logic [CNT_W-1:0] ramp_o
);

    ramp_dir_e        dir_q;
    logic [CNT_W-1:0] ramp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= RAMP_UP;
            ramp_q <= '0;
        end else if (lim_i == '0) begin
            dir_q  <= RAMP_UP;
            ramp_q <= '0;
        end else begin
            unique case (dir_q)
                RAMP_UP: begin
                    if (ramp_q >= lim_i) begin
                        dir_q  <= RAMP_DN;
                        ramp_q <= ramp_q - 1'b1;
                    end else begin
                        ramp_q <= ramp_q + 1'b1;
                    end
                end
                RAMP_DN: begin
                    if (ramp_q == '0) begin
                        dir_q  <= RAMP_UP;
                        ramp_q <= ramp_q + 1'b1;
                    end else begin
                        ramp_q <= ramp_q - 1'b1;
                    end
                end
            endcase
        end
    end

    assign ramp_o = ramp_q;

endmodule

// File: rtl/ml_spwm_slicer.sv
module ml_spwm_slicer
    import ml_spwm_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CNT_W  = 10,
    parameter int NCELL  = 2,
    parameter int LVL_W  = $clog2(2 * NCELL + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [DATA_W-1:0] ref_i,
    input  logic [1:0]              mode_i,
    input  logic [CNT_W-1:0]        lim_i,
    input  logic [CNT_W-1:0]        ramp_i,
    output logic signed [LVL_W-1:0] lvl_o
);

    localparam int NCAR  = 2 * NCELL;
    localparam int CSPAN = CNT_W + $clog2(NCELL + 1) + 1;
    localparam int CW    = ((DATA_W > CSPAN) ? DATA_W : CSPAN) + 1;
    localparam logic signed [LVL_W-1:0] MID = LVL_W'(NCELL);

    arr_mode_e               mode_e;
    logic signed [CW-1:0]    ref_x;
    logic signed [CW-1:0]    lim_x;
    logic signed [CW-1:0]    ramp_x;
    logic [NCAR-1:0]         above;
    logic [NCAR-1:0]         flip;
    logic [LVL_W-1:0]        n_above;
    logic signed [LVL_W-1:0] lvl_q;

    assign mode_e = arr_mode_e'(mode_i);
    assign ref_x  = {{(CW-DATA_W){ref_i[DATA_W-1]}}, ref_i};
    assign lim_x  = {{(CW-CNT_W){1'b0}}, lim_i};
    assign ramp_x = {{(CW-CNT_W){1'b0}}, ramp_i};

    for (genvar k = 0; k < NCAR; k++) begin : g_car
        localparam logic signed [CW-1:0] KOFF = CW'(k - NCELL);
        logic signed [CW-1:0] car;
        assign flip[k]  = carrier_flipped(mode_e, k, NCAR);
        assign car      = lim_x * KOFF + (flip[k] ? (lim_x - ramp_x) : ramp_x);
        assign above[k] = (ref_x > car);
    end

    always_comb begin
        n_above = '0;
        for (int k = 0; k < NCAR; k++) begin
            n_above = n_above + LVL_W'(above[k]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= signed'(n_above) - MID;
        end
    end

    assign lvl_o = lvl_q;

endmodule

// File: rtl/ml_spwm_cell.sv
module ml_spwm_cell
    import ml_spwm_pkg::*;
#(
    parameter int LVL_W    = 4,
    parameter int CELL_IDX = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [LVL_W-1:0] lvl_i,
    output logic [3:0]              sw_o
);

    localparam logic signed [LVL_W-1:0] THR = LVL_W'(CELL_IDX + 1);

    cell_st_e st_q, st_d;
    logic     zhi_last_q, zhi_last_d;

    // next state: drive-up, drive-down, settle, hold-zero
    always_comb begin
        st_d       = st_q;
        zhi_last_d = zhi_last_q;
        if (lvl_i >= THR) begin
            st_d = CS_POS;
        end else if (lvl_i <= -THR) begin
            st_d = CS_NEG;
        end else begin
            unique case (st_q)
                CS_POS, CS_NEG: begin
                    st_d       = zhi_last_q ? CS_ZLO : CS_ZHI;
                    zhi_last_d = !zhi_last_q;
                end
                CS_ZHI, CS_ZLO: begin
                    st_d = st_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= CS_ZLO;
            zhi_last_q <= 1'b0;
        end else begin
            st_q       <= st_d;
            zhi_last_q <= zhi_last_d;
        end
    end

    // outputs: bit0=S1, bit1=S2, bit2=S3, bit3=S4
    always_comb begin
        unique case (st_q)
            CS_POS: sw_o = 4'b1001;
            CS_NEG: sw_o = 4'b0110;
            CS_ZHI: sw_o = 4'b0011;
            CS_ZLO: sw_o = 4'b1100;
        endcase
    end

endmodule

// File: rtl/ml_spwm_deadband.sv
module ml_spwm_deadband #(
    parameter int DEAD_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_i,
    input  logic [DEAD_W-1:0] dead_i,
    output logic              gate_o
);

    logic [DEAD_W-1:0] wait_q;
    logic              gate_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q <= '0;
            gate_q <= 1'b0;
        end else if (!cmd_i) begin
            wait_q <= '0;
            gate_q <= 1'b0;
        end else if (wait_q >= dead_i) begin
            gate_q <= 1'b1;
        end else begin
            wait_q <= wait_q + 1'b1;
            gate_q <= 1'b0;
        end
    end

    assign gate_o = gate_q;

endmodule

// File: rtl/ml_spwm_gen.sv
module ml_spwm_gen
    import ml_spwm_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CNT_W  = 10,
    parameter int DEAD_W = 6,
    parameter int NCELL  = 2,
    parameter int LVL_W  = $clog2(2 * NCELL + 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [DATA_W-1:0] ref_in,
    input  logic [1:0]               arr_mode,
    input  logic [CNT_W-1:0]         ramp_lim,
    input  logic [DEAD_W-1:0]        dead_cyc,
    output logic signed [LVL_W-1:0]  lvl_o,
    output logic [4*NCELL-1:0]       gate_o
);

    localparam int NSW = 4 * NCELL;

    logic [CNT_W-1:0]        ramp;
    logic signed [LVL_W-1:0] lvl;
    logic [NSW-1:0]          sw_cmd;

    ml_spwm_ramp #(.CNT_W(CNT_W)) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .lim_i  (ramp_lim),
        .ramp_o (ramp)
    );

    ml_spwm_slicer #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .NCELL  (NCELL),
        .LVL_W  (LVL_W)
    ) u_slicer (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (ref_in),
        .mode_i (arr_mode),
        .lim_i  (ramp_lim),
        .ramp_i (ramp),
        .lvl_o  (lvl)
    );

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        ml_spwm_cell #(
            .LVL_W    (LVL_W),
            .CELL_IDX (c)
        ) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl_i (lvl),
            .sw_o  (sw_cmd[4*c +: 4])
        );
    end

    for (genvar i = 0; i < NSW; i++) begin : g_dead
        ml_spwm_deadband #(.DEAD_W(DEAD_W)) u_db (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd_i  (sw_cmd[i]),
            .dead_i (dead_cyc),
            .gate_o (gate_o[i])
        );
    end

    assign lvl_o = lvl;

endmodule

// File: rtl/ml_spwm_chk.sv
module ml_spwm_chk #(
    parameter int NCELL  = 2,
    parameter int LVL_W  = 4,
    parameter int DEAD_W = 6,
    parameter int NSW    = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic signed [LVL_W-1:0] lvl_o,
    input logic [NSW-1:0]          gate_o,
    input logic [NSW-1:0]          sw_cmd,
    input logic [DEAD_W-1:0]       dead_cyc
);

    localparam logic signed [LVL_W-1:0] LMAX = LVL_W'(NCELL);

    p_lvl_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_o <= LMAX) && (lvl_o >= -LMAX));

    for (genvar c = 0; c < NCELL; c++) begin : g_leg
        p_leg_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_o[4*c] && gate_o[4*c+2]) && !(gate_o[4*c+1] && gate_o[4*c+3]));
    end

    for (genvar i = 0; i < NSW; i++) begin : g_sw
        localparam int PARTNER = (i & ~3) | ((i & 3) ^ 2);
        p_gate_needs_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
            gate_o[i] |-> $past(sw_cmd[i]));
        p_dead_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(gate_o[i]) && (dead_cyc != '0)) |-> !$past(gate_o[PARTNER]));
    end

endmodule

bind ml_spwm_gen ml_spwm_chk #(
    .NCELL  (NCELL),
    .LVL_W  (LVL_W),
    .DEAD_W (DEAD_W),
    .NSW    (NSW)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_o    (lvl_o),
    .gate_o   (gate_o),
    .sw_cmd   (sw_cmd),
    .dead_cyc (dead_cyc)
);

// File: tb/ml_spwm_gen_tb_top.sv
module ml_spwm_gen_tb_top;

    localparam int DATA_W = 12;
    localparam int CNT_W  = 10;
    localparam int DEAD_W = 6;
    localparam int NCELL  = 2;
    localparam int LVL_W  = 4;
    localparam int NSW    = 8;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic signed [DATA_W-1:0] ref_in = '0;
    logic [1:0]               arr_mode = 2'd0;
    logic [CNT_W-1:0]         ramp_lim = 10'd20;
    logic [DEAD_W-1:0]        dead_cyc = 6'd3;
    logic signed [LVL_W-1:0]  lvl_o;
    logic [NSW-1:0]           gate_o;

    int ref_val = 0;
    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit started = 0;
    bit done = 0;

    // model state
    int m_ramp = 0, m_up = 1, m_lvl = 0, m_mode = 0, m_lim = 20;
    int m_st[NCELL];
    int m_zhi[NCELL];
    int m_cnt[NSW];
    int m_gate[NSW];

    always #5 clk = ~clk;

    ml_spwm_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (ref_in),
        .arr_mode (arr_mode),
        .ramp_lim (ramp_lim),
        .dead_cyc (dead_cyc),
        .lvl_o    (lvl_o),
        .gate_o   (gate_o)
    );

    function automatic int raw_of(int st);
        case (st)
            0: return 4'b1001;
            1: return 4'b0110;
            2: return 4'b0011;
            default: return 4'b1100;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h) at cycle %0d",
                     tag, act, act, exp, exp, cyc);
        end
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        started <= 1;
        cyc++;
        if (!rst_n) begin
            m_ramp = 0; m_up = 1; m_lvl = 0;
            for (int c = 0; c < NCELL; c++) begin m_st[c] = 3; m_zhi[c] = 0; end
            for (int i = 0; i < NSW; i++) begin m_cnt[i] = 0; m_gate[i] = 0; end
        end else begin
            int n_ab;
            for (int i = 0; i < NSW; i++) begin
                int r;
                r = (raw_of(m_st[i / 4]) >> (i % 4)) & 1;
                if (r == 0) begin m_cnt[i] = 0; m_gate[i] = 0; end
                else if (m_cnt[i] >= int'(dead_cyc)) m_gate[i] = 1;
                else begin m_cnt[i]++; m_gate[i] = 0; end
            end
            for (int c = 0; c < NCELL; c++) begin
                if (m_lvl >= c + 1) m_st[c] = 0;
                else if (m_lvl <= -(c + 1)) m_st[c] = 1;
                else if (m_st[c] < 2) begin
                    m_st[c] = m_zhi[c] ? 3 : 2;
                    m_zhi[c] = (m_st[c] == 2);
                end
            end
            n_ab = 0;
            m_mode = int'(arr_mode);
            m_lim = int'(ramp_lim);
            for (int k = 0; k < 2 * NCELL; k++) begin
                bit inv;
                int car;
                inv = (m_mode == 1) ? (k >= NCELL) : (m_mode == 2) ? (k % 2 == 1) : 1'b0;
                car = (k - NCELL) * m_lim + (inv ? (m_lim - m_ramp) : m_ramp);
                if (ref_val > car) n_ab++;
            end
            m_lvl = n_ab - NCELL;
            if (m_lim == 0) begin m_ramp = 0; m_up = 1; end
            else if (m_up == 1) begin
                if (m_ramp >= m_lim) begin m_up = 0; m_ramp--; end else m_ramp++;
            end else begin
                if (m_ramp == 0) begin m_up = 1; m_ramp++; end else m_ramp--;
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            int exp_g, raw_all, any_zero;
            string ltag, gtag;
            exp_g = 0; raw_all = 0; any_zero = 0;
            for (int i = 0; i < NSW; i++) exp_g |= m_gate[i] << i;
            for (int c = 0; c < NCELL; c++) begin
                raw_all |= raw_of(m_st[c]) << (4 * c);
                if (m_st[c] >= 2) any_zero = 1;
            end
            if (m_lim == 1) ltag = "R2";
            else if (m_mode == 1) ltag = "R5";
            else if (m_mode == 2 || m_mode == 3) ltag = "R6";
            else ltag = "R4";
            if (raw_all != exp_g) gtag = "R9";
            else if (any_zero != 0) gtag = "R8";
            else gtag = "R7";
            chk(ltag, int'(lvl_o), m_lvl);
            chk(gtag, int'(gate_o), exp_g);
            for (int c = 0; c < NCELL; c++) begin
                chk("R10", int'((gate_o[4*c] & gate_o[4*c+2]) | (gate_o[4*c+1] & gate_o[4*c+3])), 0);
            end
        end
    end

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc == 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired (R1 run incomplete) actual=%0d expected<%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic set_ref(input int v);
        ref_val = v;
        ref_in = DATA_W'(v);
    endtask

    task automatic phase(input int mode, input int lim, input int dead, input real amp, input int ncyc);
        @(negedge clk);
        rst_n = 1'b0;
        arr_mode = 2'(mode);
        ramp_lim = CNT_W'(lim);
        dead_cyc = DEAD_W'(dead);
        set_ref(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < ncyc; n++) begin
            @(negedge clk);
            set_ref($rtoi(amp * $sin(2.0 * 3.14159265 * n / 313.0)));
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", int'(gate_o), 0);
        chk("R1", int'(lvl_o), 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk("R1", int'(gate_o), 8'hCC);
        chk("R1", int'(lvl_o), 0);
        // R3: reference beyond the carrier stack saturates the level
        set_ref(41);
        repeat (3) @(negedge clk);
        chk("R3", int'(lvl_o), 2);
        set_ref(-41);
        repeat (3) @(negedge clk);
        chk("R3", int'(lvl_o), -2);
        set_ref(40);
        repeat (3) @(negedge clk);
        chk("R3", int'(lvl_o) >= 1 ? 1 : 0, 1);

        phase(0, 20, 3, 38.0, 1200);
        phase(1, 20, 2, 38.0, 1200);
        phase(1, 20, 5, 30.0, 900);
        phase(2, 20, 0, 38.0, 1200);
        phase(3, 20, 1, 38.0, 700);
        phase(0, 1, 1, 2.5, 300);
        phase(2, 1, 2, 2.5, 300);
        phase(1, 1, 1, 2.5, 300);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule